// File: doc/BRIEF.md
# Ethernet Pause Frame Detector

This block sits beside the receive side of an Ethernet MAC and watches the byte stream of each incoming frame. It picks the type, opcode and pause-time fields out of the header at fixed byte positions and counts the frame's length. When the end-of-frame status arrives, it decides whether the frame was a valid flow-control pause frame. A frame qualifies only if four things hold. Its destination address was accepted by one of the first two individual address filters, and that filter's flow-control enable is set. Its type field equals a programmable value. Its opcode is 0x0001. Its length and CRC are good.

For an accepted frame the block issues a one-cycle load strobe together with the 16-bit pause time, meant for the transmit flow-control timer. A configuration bit selects whether an accepted pause frame still travels on to the host or is dropped. A drop flag reports that choice in the same cycle as the load strobe. CRC computation, address filtering and host buffering are done elsewhere. The type value is normally programmed to 0x8808.

Top module: `pause_frame_detector`

## Requirements
- R1: A load needs at least one index i (0 or 1) where both `ia_hit[i]` and `fc_enable[i]` are 1, sampled on the status cycle. A filter hit whose enable is 0 does not qualify, and neither does an enable without a hit.
- R2: The frame bytes at positions 12 and 13 are counted from 0 at the first destination address byte. Read big-endian, with byte 12 as the high byte, they must equal `fc_type` as sampled on the frame's last byte.
- R3: Bytes 14 and 15, read big-endian, must equal 0x0001. Any other opcode gives no load.
- R4: The frame length counts every byte from the byte marked start through the byte marked end, inclusive. It must lie in 64..1518, and `stat_crc_ok` must be 1 on the status cycle. Otherwise no load occurs.
- R5: `pause_load` is a single-cycle pulse. It rises in the cycle after the clock edge that samples `stat_valid`, and it never appears without a status strobe.
- R6: `frame_drop` pulses together with `pause_load` when `cfg_pass_host` was 0 on the status cycle. It is 0 in every other cycle.
- R7: On a load, `pause_time` takes the value of bytes 16 and 17, read big-endian. It holds its value in every cycle without a load.
- R8: While reset is asserted, `pause_load`, `frame_drop` and `pause_time` are 0.
- R9: A status strobe with no completed frame pending is ignored, and so is a second strobe for the same frame. Bytes that arrive outside a frame, with no start marker since the last end, are ignored and can never complete a frame.
- R10: A start marker in the middle of a frame abandons that frame. Counting and field capture restart, and the abandoned frame never yields a load.
- R11: A status strobe for one frame may arrive in the same cycle as the first byte of the next frame. The decision for the earlier frame and the capture of the new frame are both unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_valid | input | 1 | A receive byte is present on `rx_data` |
| rx_sof | input | 1 | Marks the first byte of a frame (qualified by `rx_valid`) |
| rx_eof | input | 1 | Marks the last byte of a frame (qualified by `rx_valid`) |
| rx_data | input | 8 | Receive byte |
| fc_type | input | 16 | Programmed type value a pause frame must carry |
| ia_hit | input | 2 | Bit i: destination address accepted by individual filter i |
| fc_enable | input | 2 | Bit i: flow-control enable for individual filter i |
| cfg_pass_host | input | 1 | 1: accepted pause frames go to the host; 0: they are dropped |
| stat_valid | input | 1 | End-of-frame status strobe, at least one cycle after the last byte |
| stat_crc_ok | input | 1 | CRC result, qualified by `stat_valid` |
| pause_load | output | 1 | One-cycle strobe loading the flow-control timer |
| pause_time | output | 16 | Pause time of the last accepted pause frame |
| frame_drop | output | 1 | Accepted pause frame is to be discarded, with `pause_load` |

## Verification
Two functions can fall in the same cycle: the decision on a finished frame and the start of capture for the next one. The bench provokes this by holding back the status strobe of a qualifying frame and driving it on the cycle that carries the next frame's start byte. That next frame has a different pause time. The scoreboard expects the first decision to carry the first frame's pause time. It expects the second frame, with its own status, to load its own value, so any sharing of counter or field state between the two shows up as a wrong time or a missing strobe.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned FIELD_W  = 16;
  localparam int unsigned HDR_BYTES = 6;
  localparam int unsigned POS_FIRST = 12;
  localparam logic [FIELD_W-1:0] OPC_PAUSE = 16'h0001;

  typedef struct packed {
    logic [FIELD_W-1:0] ftype;
    logic [FIELD_W-1:0] opcode;
    logic [FIELD_W-1:0] ptime;
  } pfd_fields_t;
endpackage

// File: rtl/pfd_frame_tracker.sv
module pfd_frame_tracker #(
  parameter int unsigned LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic             rx_sof,
  input  logic             rx_eof,
  output logic             byte_en,
  output logic [LEN_W-1:0] byte_idx,
  output logic             frame_end,
  output logic [LEN_W-1:0] frame_len
);
  localparam logic [LEN_W-1:0] LEN_SAT = {LEN_W{1'b1}};

  logic             in_frame_q, in_frame_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W:0]   len_wide;

  always_comb begin
    byte_en   = rx_valid && (rx_sof || in_frame_q);
    byte_idx  = rx_sof ? '0 : cnt_q;
    len_wide  = {1'b0, byte_idx} + 1'b1;
    frame_len = len_wide[LEN_W] ? LEN_SAT : len_wide[LEN_W-1:0];
    frame_end = byte_en && rx_eof;
    in_frame_d = in_frame_q;
    cnt_d      = cnt_q;
    if (byte_en) begin
      in_frame_d = !rx_eof;
      cnt_d      = frame_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
    end else if (byte_en) begin
      in_frame_q <= in_frame_d;
      cnt_q      <= cnt_d;
    end
  end
endmodule

// File: rtl/pfd_field_capture.sv
module pfd_field_capture
  import pfd_pkg::*;
#(
  parameter int unsigned LEN_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_en,
  input  logic [LEN_W-1:0]  byte_idx,
  input  logic [BYTE_W-1:0] rx_data,
  output pfd_fields_t       fields
);
  logic [BYTE_W-1:0] hdr [HDR_BYTES];

  for (genvar k = 0; k < HDR_BYTES; k++) begin : g_hdr
    logic [BYTE_W-1:0] b_q;
    logic              take;
    assign take = byte_en && (byte_idx == LEN_W'(POS_FIRST + k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    b_q <= '0;
      else if (take) b_q <= rx_data;
    end
    assign hdr[k] = b_q;
  end

  assign fields.ftype  = {hdr[0], hdr[1]};
  assign fields.opcode = {hdr[2], hdr[3]};
  assign fields.ptime  = {hdr[4], hdr[5]};
endmodule

// File: rtl/pfd_decide.sv
module pfd_decide
  import pfd_pkg::*;
#(
  parameter int unsigned LEN_W   = 11,
  parameter int unsigned MIN_LEN = 64,
  parameter int unsigned MAX_LEN = 1518,
  parameter int unsigned FILT_N  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_end,
  input  logic [LEN_W-1:0]   frame_len,
  input  pfd_fields_t        fields,
  input  logic [FIELD_W-1:0] fc_type,
  input  logic               stat_valid,
  input  logic               stat_crc_ok,
  input  logic [FILT_N-1:0]  ia_hit,
  input  logic [FILT_N-1:0]  fc_enable,
  input  logic               cfg_pass_host,
  output logic               pause_load,
  output logic [FIELD_W-1:0] pause_time,
  output logic               frame_drop
);
  logic               pend_q, pend_d;
  logic               pend_ok_q, pend_ok_d;
  logic [FIELD_W-1:0] pend_time_q, pend_time_d;
  logic               shape_ok, accept;
  logic               load_q, drop_q;
  logic [FIELD_W-1:0] time_q;

  always_comb begin
    shape_ok = (frame_len >= LEN_W'(MIN_LEN)) && (frame_len <= LEN_W'(MAX_LEN))
            && (fields.ftype == fc_type) && (fields.opcode == OPC_PAUSE);
    accept   = stat_valid && pend_q && pend_ok_q && stat_crc_ok
            && (|(ia_hit & fc_enable));
    pend_d      = pend_q;
    pend_ok_d   = pend_ok_q;
    pend_time_d = pend_time_q;
    if (frame_end) begin
      pend_d      = 1'b1;
      pend_ok_d   = shape_ok;
      pend_time_d = fields.ptime;
    end else if (stat_valid) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_ok_q   <= 1'b0;
      pend_time_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (frame_end) begin
        pend_ok_q   <= pend_ok_d;
        pend_time_q <= pend_time_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= 1'b0;
      drop_q <= 1'b0;
      time_q <= '0;
    end else begin
      load_q <= accept;
      drop_q <= accept && !cfg_pass_host;
      if (accept) time_q <= pend_time_q;
    end
  end

  assign pause_load = load_q;
  assign frame_drop = drop_q;
  assign pause_time = time_q;
endmodule

// File: rtl/pause_frame_detector.sv
module pause_frame_detector
  import pfd_pkg::*;
#(
  parameter int unsigned MIN_LEN = 64,
  parameter int unsigned MAX_LEN = 1518,
  parameter int unsigned FILT_N  = 2,
  localparam int unsigned LEN_W  = $clog2(MAX_LEN + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_valid,
  input  logic               rx_sof,
  input  logic               rx_eof,
  input  logic [BYTE_W-1:0]  rx_data,
  input  logic [FIELD_W-1:0] fc_type,
  input  logic [FILT_N-1:0]  ia_hit,
  input  logic [FILT_N-1:0]  fc_enable,
  input  logic               cfg_pass_host,
  input  logic               stat_valid,
  input  logic               stat_crc_ok,
  output logic               pause_load,
  output logic [FIELD_W-1:0] pause_time,
  output logic               frame_drop
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             byte_en, frame_end;
  logic [LEN_W-1:0] byte_idx, frame_len;
  pfd_fields_t      fields;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pfd_frame_tracker #(.LEN_W(LEN_W)) u_track (
    .clk(clk), .rst_n(rst_int_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .byte_en(byte_en), .byte_idx(byte_idx),
    .frame_end(frame_end), .frame_len(frame_len)
  );

  pfd_field_capture #(.LEN_W(LEN_W)) u_cap (
    .clk(clk), .rst_n(rst_int_n), .byte_en(byte_en), .byte_idx(byte_idx),
    .rx_data(rx_data), .fields(fields)
  );

  pfd_decide #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN),
               .FILT_N(FILT_N)) u_dec (
    .clk(clk), .rst_n(rst_int_n), .frame_end(frame_end),
    .frame_len(frame_len), .fields(fields), .fc_type(fc_type),
    .stat_valid(stat_valid), .stat_crc_ok(stat_crc_ok), .ia_hit(ia_hit),
    .fc_enable(fc_enable), .cfg_pass_host(cfg_pass_host),
    .pause_load(pause_load), .pause_time(pause_time),
    .frame_drop(frame_drop)
  );
endmodule

// File: rtl/pfd_checker.sv
module pfd_checker #(
  parameter int unsigned FILT_N = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stat_valid,
  input logic              stat_crc_ok,
  input logic [FILT_N-1:0] ia_hit,
  input logic [FILT_N-1:0] fc_enable,
  input logic              cfg_pass_host,
  input logic              pause_load,
  input logic [15:0]       pause_time,
  input logic              frame_drop
);
  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pause_load |=> !pause_load); // R5
  AST_LOAD_AFTER_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    pause_load |-> $past(stat_valid && stat_crc_ok)); // R4
  AST_LOAD_NEEDS_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    pause_load |-> $past(|(ia_hit & fc_enable))); // R1
  AST_DROP_WITH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    frame_drop |-> pause_load && $past(!cfg_pass_host)); // R6
  AST_PASS_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_load && !frame_drop) |-> $past(cfg_pass_host)); // R6
  AST_TIME_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !pause_load |-> $stable(pause_time)); // R7
endmodule

bind pause_frame_detector pfd_checker #(.FILT_N(FILT_N)) u_pfd_chk (
  .clk(clk), .rst_n(rst_n), .stat_valid(stat_valid), .stat_crc_ok(stat_crc_ok),
  .ia_hit(ia_hit), .fc_enable(fc_enable), .cfg_pass_host(cfg_pass_host),
  .pause_load(pause_load), .pause_time(pause_time), .frame_drop(frame_drop)
);

// File: tb/pause_frame_detector_bench.sv
module pause_frame_detector_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_valid, rx_sof, rx_eof;
  logic [7:0]  rx_data;
  logic [15:0] fc_type;
  logic [1:0]  ia_hit, fc_enable;
  logic        cfg_pass_host, stat_valid, stat_crc_ok;
  logic        pause_load, frame_drop;
  logic [15:0] pause_time;

  always #2.5 clk = ~clk;

  pause_frame_detector u_pause_frame_detector (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_data(rx_data), .fc_type(fc_type), .ia_hit(ia_hit),
    .fc_enable(fc_enable), .cfg_pass_host(cfg_pass_host),
    .stat_valid(stat_valid), .stat_crc_ok(stat_crc_ok),
    .pause_load(pause_load), .pause_time(pause_time), .frame_drop(frame_drop)
  );

  typedef struct { bit load; bit drop; logic [15:0] ptime; string tag; } exp_t;
  exp_t q[$];

  int n_chk = 0, n_fail = 0;
  bit mon_on = 0, mon_stat = 0, done = 0;
  logic [15:0] held_time = 16'h0;
  bit b_pend = 0, b_shape = 0;
  logic [15:0] b_time = 16'h0;
  bit d_crc; logic [1:0] d_hit, d_en; bit d_pass; string d_tag;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_at(int i, logic [15:0] t, logic [15:0] o,
                                         logic [15:0] p);
    case (i)
      12: return t[15:8];  13: return t[7:0];
      14: return o[15:8];  15: return o[7:0];
      16: return p[15:8];  17: return p[7:0];
      default: return 8'(i * 7 + 3);
    endcase
  endfunction

  // drives the status fields and pushes the expected decision
  task automatic put_stat(bit crc, logic [1:0] hit, logic [1:0] en, bit pass,
                          string tag);
    exp_t e;
    stat_valid = 1'b1; stat_crc_ok = crc; ia_hit = hit; fc_enable = en;
    cfg_pass_host = pass;
    e.load  = b_pend && b_shape && crc && ((hit & en) != 2'b00);
    e.drop  = e.load && !pass;
    e.ptime = b_time;
    e.tag   = tag;
    b_pend  = 0;
    q.push_back(e);
  endtask

  task automatic send(int len, logic [15:0] t, logic [15:0] o, logic [15:0] p,
                      bit with_sof, bit with_eof, bit stat_first);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      stat_valid = 1'b0;
      if (i == 0 && stat_first) put_stat(d_crc, d_hit, d_en, d_pass, d_tag);
      rx_valid = 1'b1;
      rx_sof   = with_sof && (i == 0);
      rx_eof   = with_eof && (i == len - 1);
      rx_data  = byte_at(i, t, o, p);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; stat_valid = 1'b0;
    if (with_sof && with_eof) begin
      b_pend  = 1;
      b_shape = (len >= 64) && (len <= 1518) && (t == fc_type) && (o == 16'h0001);
      b_time  = p;
    end
  endtask

  task automatic stat(bit crc, logic [1:0] hit, logic [1:0] en, bit pass,
                      string tag);
    @(negedge clk);
    put_stat(crc, hit, en, pass, tag);
    @(negedge clk);
    stat_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  always @(posedge clk) mon_stat <= stat_valid;

  always @(negedge clk) begin
    if (mon_on) begin
      if (mon_stat) begin
        if (q.size() == 0) chk("R9 decision without expectation", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(e.tag, pause_load, e.load);
          chk(e.tag, frame_drop, e.drop);
          if (e.load) held_time = e.ptime;
          chk({e.tag, " R7 time"}, pause_time, held_time);
        end
      end else begin
        chk("R5 R6 no pulse without status", {pause_load, frame_drop}, 2'b00);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_data = 0;
    fc_type = 16'h8808; ia_hit = 0; fc_enable = 0; cfg_pass_host = 1;
    stat_valid = 0; stat_crc_ok = 0;
    repeat (4) @(negedge clk);
    chk("R8 reset load", pause_load, 0);
    chk("R8 reset drop", frame_drop, 0);
    chk("R8 reset time", pause_time, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    mon_on = 1;

    send(64, 16'h8808, 16'h0001, 16'h1234, 1, 1, 0);
    stat(1, 2'b01, 2'b01, 1, "R1 R4 good 64 filter0 pass");
    send(1518, 16'h8808, 16'h0001, 16'hBEEF, 1, 1, 0);
    stat(1, 2'b10, 2'b10, 0, "R4 R6 good 1518 filter1 drop");
    send(64, 16'h8808, 16'h0001, 16'h1111, 1, 1, 0);
    stat(1, 2'b01, 2'b10, 0, "R1 hit without enable");
    send(64, 16'h8809, 16'h0001, 16'h2222, 1, 1, 0);
    stat(1, 2'b11, 2'b11, 1, "R2 wrong type");
    send(64, 16'h8808, 16'h0002, 16'h3333, 1, 1, 0);
    stat(1, 2'b11, 2'b11, 1, "R3 wrong opcode");
    send(63, 16'h8808, 16'h0001, 16'h4444, 1, 1, 0);
    stat(1, 2'b11, 2'b11, 1, "R4 length 63");
    send(1519, 16'h8808, 16'h0001, 16'h5555, 1, 1, 0);
    stat(1, 2'b11, 2'b11, 1, "R4 length 1519");
    send(100, 16'h8808, 16'h0001, 16'h6666, 1, 1, 0);
    stat(0, 2'b11, 2'b11, 1, "R4 bad crc");
    stat(1, 2'b11, 2'b11, 1, "R9 second status same frame");
    send(70, 16'h8808, 16'h0001, 16'h7777, 0, 1, 0);
    stat(1, 2'b11, 2'b11, 1, "R9 bytes outside frame");
    send(64, 16'h8808, 16'h0001, 16'h0A0A, 1, 1, 0);
    stat(1, 2'b01, 2'b01, 0, "R6 R7 reload drop");

    send(20, 16'h8808, 16'h0001, 16'h9999, 1, 0, 0);
    send(64, 16'h8809, 16'h0001, 16'h8888, 1, 1, 0);
    stat(1, 2'b11, 2'b11, 1, "R10 abandoned frame no load");
    send(40, 16'h8808, 16'h0001, 16'hAAAA, 1, 0, 0);
    send(1500, 16'h8808, 16'h0001, 16'hBBBB, 1, 1, 0);
    stat(1, 2'b01, 2'b01, 1, "R10 restart count 1500");

    fc_type = 16'h1234;
    send(80, 16'h1234, 16'h0001, 16'hC0DE, 1, 1, 0);
    stat(1, 2'b10, 2'b10, 1, "R2 programmed type");
    fc_type = 16'h8808;

    send(64, 16'h8808, 16'h0001, 16'hD00D, 1, 1, 0);
    d_crc = 1; d_hit = 2'b01; d_en = 2'b11; d_pass = 1; d_tag = "R11 status with next sof";
    send(64, 16'h8808, 16'h0001, 16'hE00E, 1, 1, 1);
    stat(1, 2'b10, 2'b11, 0, "R11 following frame");

    repeat (4) @(negedge clk);
    chk("R9 all decisions seen", q.size(), 0);
    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule